// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

A single-clock first-in first-out buffer with a write side gated by an enable and a chip select, and a read side gated by an enable and a read select. The read select also gates the data output one cycle later. A flag-mode select, latched only during master reset, chooses one of two behaviours. In the standard mode a word reaches the output register one cycle after an enabled read, and an empty flag reports that no word is stored. In the fall-through mode the head word is loaded into the output register without a read, and a ready flag reports that the output holds a valid word.

The read side can be replayed. A mark pulse records the position of the next word the consumer will receive. A rewind pulse moves the read pointer back to that position, or to location zero if no mark is held. The write pointer is left alone. A flush input (partial reset) clears both pointers, the mark and the output register, and keeps the latched flag mode. A typical use is a packet buffer that may need to resend a frame: mark at the frame start, and rewind if the receiver rejects it.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers, the mark, the flags and the output register are cleared at each clock edge, and `fwft_sel_i` is latched as the flag mode (0 = standard, 1 = fall-through). Outside master reset `fwft_sel_i` has no effect. After master reset the buffer is empty and a later rewind goes to location zero.
- R2: A word is stored at a clock edge only when `wr_en_i` and `wr_cs_i` are both high and `full_o` is low. `full_o` is high when 2**ADDR_W words are held in storage. A write while full changes nothing.
- R3: In standard mode an enabled read (`rd_en_i` and `rd_cs_i` high) moves the oldest stored word into the output register at that edge, in write order. `empty_o` is high when no word is stored. A read while `empty_o` is high changes neither the pointers nor the output. `ready_o` stays 0 in this mode.
- R4: In fall-through mode, a word written at edge k into an empty buffer is in the output register with `ready_o` high after edge k+1, with no read. An enabled read while `ready_o` is high consumes that word and loads the next one at the same edge, if one is stored. The output register adds one place, so capacity is 2**ADDR_W+1. A read while `ready_o` is low is ignored. `empty_o` stays 0 in this mode.
- R5: `rd_cs_i` is sampled at each edge. After an edge where it was low, `rd_data_o` reads zero. After an edge where it was high, `rd_data_o` shows the output register. A read requires `rd_cs_i` high.
- R6: A `flush_i` pulse clears both pointers, the mark and the output register, and keeps the latched flag mode.
- R7: A `mark_i` pulse records the position of the next word the consumer will receive. In standard mode that is the read pointer. In fall-through mode it is the word shown on the output while `ready_o` is high.
- R8: A `rewind_i` pulse loads the read pointer with the recorded mark, or with zero if no mark is held, and leaves the write pointer unchanged. Afterwards `level_o` equals the write pointer minus the restored read pointer.
- R9: After a rewind edge, `empty_o` is high for one cycle in standard mode and no read is taken in that cycle. In fall-through mode `ready_o` is low for two cycles, and the restored head word is presented after the second edge.
- R10: When a rewind falls in the same cycle as a write, both take effect. A read or a mark in the rewind cycle is ignored.
- R11: `level_o` reports the number of words in storage that have not been moved to the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous master reset, active low |
| fwft_sel_i | input | 1 | Flag mode select, latched during master reset |
| flush_i | input | 1 | Synchronous partial reset, active high |
| wr_en_i | input | 1 | Write enable |
| wr_cs_i | input | 1 | Write chip select, second write qualifier |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read enable |
| rd_cs_i | input | 1 | Read select, qualifies reads and gates the output |
| mark_i | input | 1 | Record the current read position |
| rewind_i | input | 1 | Rewind the read pointer |
| rd_data_o | output | DATA_W | Output register, zero when the read select was low |
| empty_o | output | 1 | Standard-mode empty flag |
| ready_o | output | 1 | Fall-through-mode output-valid flag |
| full_o | output | 1 | Storage full |
| level_o | output | ADDR_W+1 | Words held in storage |

## Verification
A rewind can land in the same edge as a write, a read and a mark. Each of these acts on the pointers, so the design has to order them. The bench builds a marked, partly read buffer and then drives rewind, write, read and mark together for one cycle. The outcome is judged from the ports. `level_o` must equal the new write count minus the old mark, which shows that the write landed while the read and the mark were dropped. A second rewind after one more read must produce the same level. The replayed words must then come out in their original order, followed by the word written in the rewind cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } flag_mode_e;

endpackage

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells_q[raddr_i];

endmodule

// File: rtl/rwf_outreg.sv
module rwf_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              cs_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] word_q;
  logic              drive_q;

  always_ff @(posedge clk) begin
    if (clear_i) begin
      word_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= cs_i;
      if (load_i) word_q <= din_i;
    end
  end

  assign dout_o = drive_q ? word_q : '0;

endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft_sel_i,
  input  logic              flush_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic              mark_i,
  input  logic              rewind_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              load_o,
  output logic              empty_o,
  output logic              ready_o,
  output logic              full_o,
  output logic [ADDR_W:0]   level_o,
  output logic [ADDR_W:0]   wr_ptr_o,
  output logic [ADDR_W:0]   rd_ptr_o,
  output logic [ADDR_W:0]   mark_ptr_o,
  output logic              mark_ok_o,
  output logic              fwft_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  function automatic logic [PW-1:0] mark_point(input logic [PW-1:0] r, input logic fw, input logic v);
    return r - PW'(fw & v);
  endfunction

  function automatic logic [PW-1:0] rewind_target(input logic ok, input logic [PW-1:0] m);
    return ok ? m : '0;
  endfunction

  flag_mode_e    mode_q;
  logic [PW-1:0] wr_q, rd_q, mk_q;
  logic          mk_ok_q, hold_q, valid_q;

  logic          fwft, stored, full;
  logic [PW-1:0] level;
  logic          ev_write, ev_rewind, ev_mark, ev_read_std, ev_take, ev_fetch, ev_load;

  always_comb begin
    fwft        = (mode_q == MODE_FWFT);
    level       = occupancy(wr_q, rd_q);
    stored      = (level != '0);
    full        = (level == PW'(DEPTH));
    ev_write    = wr_req_i & ~full;
    ev_rewind   = rewind_i;
    ev_mark     = mark_i & ~rewind_i;
    ev_read_std = ~fwft & rd_req_i & stored & ~hold_q & ~rewind_i;
    ev_take     = fwft & rd_req_i & valid_q & ~rewind_i;
    ev_fetch    = fwft & stored & ~hold_q & ~rewind_i & (~valid_q | ev_take);
    ev_load     = ev_read_std | ev_fetch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= flag_mode_e'(fwft_sel_i);
      wr_q    <= '0;
      rd_q    <= '0;
      mk_q    <= '0;
      mk_ok_q <= 1'b0;
      hold_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      mk_q    <= '0;
      mk_ok_q <= 1'b0;
      hold_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (ev_write) wr_q <= wr_q + 1'b1;
      if (ev_rewind)    rd_q <= rewind_target(mk_ok_q, mk_q);
      else if (ev_load) rd_q <= rd_q + 1'b1;
      if (ev_mark) begin
        mk_q    <= mark_point(rd_q, fwft, valid_q);
        mk_ok_q <= 1'b1;
      end
      hold_q <= ev_rewind;
      if (ev_rewind)     valid_q <= 1'b0;
      else if (ev_fetch) valid_q <= 1'b1;
      else if (ev_take)  valid_q <= 1'b0;
    end
  end

  assign we_o       = ev_write;
  assign waddr_o    = wr_q[ADDR_W-1:0];
  assign raddr_o    = rd_q[ADDR_W-1:0];
  assign load_o     = ev_load;
  assign empty_o    = ~fwft & (~stored | hold_q);
  assign ready_o    = fwft & valid_q;
  assign full_o     = full;
  assign level_o    = level;
  assign wr_ptr_o   = wr_q;
  assign rd_ptr_o   = rd_q;
  assign mark_ptr_o = mk_q;
  assign mark_ok_o  = mk_ok_q;
  assign fwft_o     = fwft;

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft_sel_i,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic              wr_cs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_cs_i,
  input  logic              mark_i,
  input  logic              rewind_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              ready_o,
  output logic              full_o,
  output logic [ADDR_W:0]   level_o
);
  localparam int PW = ADDR_W + 1;

  logic              wr_req, rd_req, we, load, clear_out;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] head_word;
  logic [PW-1:0]     wr_ptr_w, rd_ptr_w, mark_ptr_w;
  logic              mark_ok_w, fwft_w;

  assign wr_req    = wr_en_i & wr_cs_i;
  assign rd_req    = rd_en_i & rd_cs_i;
  assign clear_out = ~rst_n | flush_i;

  rwf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwft_sel_i (fwft_sel_i),
    .flush_i    (flush_i),
    .wr_req_i   (wr_req),
    .rd_req_i   (rd_req),
    .mark_i     (mark_i),
    .rewind_i   (rewind_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .load_o     (load),
    .empty_o    (empty_o),
    .ready_o    (ready_o),
    .full_o     (full_o),
    .level_o    (level_o),
    .wr_ptr_o   (wr_ptr_w),
    .rd_ptr_o   (rd_ptr_w),
    .mark_ptr_o (mark_ptr_w),
    .mark_ok_o  (mark_ok_w),
    .fwft_o     (fwft_w)
  );

  rwf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (head_word)
  );

  rwf_outreg #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .clear_i (clear_out),
    .load_i  (load),
    .din_i   (head_word),
    .cs_i    (rd_cs_i),
    .dout_o  (rd_data_o)
  );

endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              rd_cs_i,
  input logic              rewind_i,
  input logic              fwft,
  input logic              empty_o,
  input logic              ready_o,
  input logic              full_o,
  input logic [ADDR_W:0]   level_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [ADDR_W:0]   wr_ptr,
  input logic [ADDR_W:0]   rd_ptr,
  input logic [ADDR_W:0]   mark_ptr,
  input logic              mark_ok
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  a_r2_write_blocked_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !flush_i) |=> $stable(wr_ptr));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= PW'(DEPTH));

  a_r3_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !rewind_i && !flush_i) |=> $stable(rd_ptr));

  a_r5_select_gates_output: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cs_i |=> (rd_data_o == '0));

  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (wr_ptr == '0 && rd_ptr == '0 && rd_data_o == '0 && !mark_ok));

  a_r6_flush_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> $stable(fwft));

  a_r8_rewind_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && !flush_i) |=> (rd_ptr == ($past(mark_ok) ? $past(mark_ptr) : '0)));

  a_r9_rewind_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && !flush_i) |=> (fwft ? !ready_o : empty_o));

endmodule

bind rewind_fifo rewind_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_i   (flush_i),
  .rd_cs_i   (rd_cs_i),
  .rewind_i  (rewind_i),
  .fwft      (fwft_w),
  .empty_o   (empty_o),
  .ready_o   (ready_o),
  .full_o    (full_o),
  .level_o   (level_o),
  .rd_data_o (rd_data_o),
  .wr_ptr    (wr_ptr_w),
  .rd_ptr    (rd_ptr_w),
  .mark_ptr  (mark_ptr_w),
  .mark_ok   (mark_ok_w)
);

// File: tb/tb_rewind_fifo.sv
module tb_rewind_fifo;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, fwft_sel, flush, wr_en, wr_cs, rd_en, rd_cs, mark, rewind;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic empty, ready, full;
  logic [AW:0] level;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rewind_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .fwft_sel_i(fwft_sel), .flush_i(flush),
    .wr_en_i(wr_en), .wr_cs_i(wr_cs), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_cs_i(rd_cs), .mark_i(mark), .rewind_i(rewind),
    .rd_data_o(rd_data), .empty_o(empty), .ready_o(ready), .full_o(full), .level_o(level)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mreset(input logic m);
    rst_n = 1'b0; fwft_sel = m;
    step(); step();
    rst_n = 1'b1; fwft_sel = ~m;
  endtask

  task automatic do_flush();
    flush = 1'b1; step(); flush = 1'b0;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_cs = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_cs = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic do_rewind();
    rewind = 1'b1; step(); rewind = 1'b0;
  endtask

  task automatic do_mark();
    mark = 1'b1; step(); mark = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fwft_sel = 1'b0; flush = 1'b0; wr_en = 1'b0; wr_cs = 1'b0;
    rd_en = 1'b0; rd_cs = 1'b1; mark = 1'b0; rewind = 1'b0; wr_data = '0;

    // ---------------- standard mode ----------------
    mreset(1'b0);
    chk("R1", "empty after reset", int'(empty), 1);
    chk("R1", "ready after reset", int'(ready), 0);
    chk("R1", "full after reset", int'(full), 0);
    chk("R1", "level after reset", int'(level), 0);
    chk("R1", "data after reset", int'(rd_data), 0);

    // R2/R3 sweep over every fill depth
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        wr(8'(16 * n + i));
        chk("R11", "level while filling", int'(level), i + 1);
      end
      chk("R2", "full at depth", int'(full), int'(n == DEPTH));
      for (int i = 0; i < n; i++) begin
        rd();
        chk("R3", "read order", int'(rd_data), 16 * n + i);
        chk("R11", "level while draining", int'(level), n - 1 - i);
      end
      chk("R3", "empty after drain", int'(empty), 1);
    end

    // overflow and underflow
    for (int i = 0; i <= DEPTH; i++) wr(8'(8'h50 + i));
    chk("R2", "write while full ignored", int'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R2", "data after overflow", int'(rd_data), 8'h50 + i);
    end
    rd();
    chk("R3", "read while empty keeps output", int'(rd_data), 8'h50 + DEPTH - 1);
    chk("R3", "read while empty keeps level", int'(level), 0);

    // chip select on write side
    wr_en = 1'b1; wr_cs = 1'b0; wr_data = 8'h77; step(); wr_en = 1'b0;
    chk("R2", "write without select ignored", int'(level), 0);

    // read select gating
    wr(8'h61); rd();
    chk("R5", "data with select", int'(rd_data), 8'h61);
    rd_cs = 1'b0; step();
    chk("R5", "data zero after select low", int'(rd_data), 0);
    wr(8'h62);
    rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R5", "read without select ignored", int'(level), 1);
    rd_cs = 1'b1; step();
    chk("R5", "output restored", int'(rd_data), 8'h61);
    rd();
    chk("R5", "next read after select", int'(rd_data), 8'h62);
    chk("R1", "mode select ignored outside reset", int'(ready), 0);

    // flush
    wr(8'h70); wr(8'h71);
    do_flush();
    chk("R6", "flush level", int'(level), 0);
    chk("R6", "flush empty", int'(empty), 1);
    chk("R6", "flush data", int'(rd_data), 0);
    chk("R6", "flush keeps standard mode", int'(ready), 0);

    // rewind to zero
    for (int i = 0; i < DEPTH; i++) wr(8'hA0 + 8'(i));
    rd(); rd();
    chk("R3", "second word", int'(rd_data), 8'hA1);
    do_rewind();
    chk("R9", "empty forced after rewind", int'(empty), 1);
    chk("R8", "level after zero rewind", int'(level), DEPTH);
    step();
    chk("R9", "empty released", int'(empty), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R8", "replay from zero", int'(rd_data), 8'hA0 + i);
    end

    // mark then rewind
    do_flush();
    for (int i = 0; i < DEPTH; i++) wr(8'hB0 + 8'(i));
    rd(); do_mark(); rd(); rd();
    do_rewind();
    chk("R7", "level after marked rewind", int'(level), DEPTH - 1);
    step();
    for (int i = 1; i < DEPTH; i++) begin
      rd();
      chk("R7", "replay from mark", int'(rd_data), 8'hB0 + i);
    end

    // rewind together with write, read and mark
    do_flush();
    wr(8'hC0); wr(8'hC1); wr(8'hC2);
    rd(); do_mark(); rd();
    rewind = 1'b1; mark = 1'b1; rd_en = 1'b1;
    wr_en = 1'b1; wr_cs = 1'b1; wr_data = 8'hC3;
    step();
    rewind = 1'b0; mark = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_cs = 1'b0;
    chk("R10", "write lands and read dropped", int'(level), 3);
    chk("R10", "empty in rewind cycle", int'(empty), 1);
    step();
    rd();
    chk("R10", "first replay word", int'(rd_data), 8'hC1);
    do_rewind();
    chk("R10", "mark in rewind cycle ignored", int'(level), 3);
    step();
    for (int i = 1; i < 4; i++) begin
      rd();
      chk("R10", "replay includes new word", int'(rd_data), 8'hC0 + i);
    end

    // master reset clears the mark
    mreset(1'b0);
    wr(8'hD0); wr(8'hD1); rd();
    do_rewind();
    chk("R1", "rewind after master reset goes to zero", int'(level), 2);
    step(); rd();
    chk("R1", "replay after master reset", int'(rd_data), 8'hD0);

    // ---------------- fall-through mode ----------------
    mreset(1'b1);
    chk("R1", "fwft ready after reset", int'(ready), 0);
    chk("R4", "fwft empty held low", int'(empty), 0);
    wr(8'hE0);
    chk("R4", "not ready one edge after write", int'(ready), 0);
    chk("R4", "word in storage", int'(level), 1);
    step();
    chk("R4", "ready after second edge", int'(ready), 1);
    chk("R4", "first word falls through", int'(rd_data), 8'hE0);
    for (int i = 1; i <= DEPTH; i++) wr(8'hE0 + 8'(i));
    chk("R4", "full with output slot", int'(full), 1);
    wr(8'hEF);
    chk("R4", "extra write ignored", int'(level), DEPTH);
    chk("R4", "empty still low", int'(empty), 0);
    for (int i = 1; i <= DEPTH; i++) begin
      rd();
      chk("R4", "fwft read order", int'(rd_data), 8'hE0 + i);
    end
    rd();
    chk("R4", "ready drops when drained", int'(ready), 0);
    rd();
    chk("R4", "read while not ready ignored", int'(rd_data), 8'hE0 + DEPTH);

    do_flush();
    chk("R6", "fwft flush data", int'(rd_data), 0);
    chk("R6", "fwft flush ready", int'(ready), 0);
    wr(8'hF0); step();
    chk("R6", "mode kept after flush", int'(ready), 1);
    chk("R6", "fall-through after flush", int'(rd_data), 8'hF0);

    // fwft mark + rewind
    do_flush();
    for (int i = 0; i < DEPTH; i++) wr(8'h90 + 8'(i));
    chk("R4", "head shown while filling", int'(rd_data), 8'h90);
    rd();
    do_mark();
    rd();
    chk("R4", "fwft third word", int'(rd_data), 8'h92);
    do_rewind();
    chk("R9", "ready low after rewind", int'(ready), 0);
    chk("R8", "fwft level after rewind", int'(level), DEPTH - 1);
    step();
    chk("R9", "ready still low", int'(ready), 0);
    step();
    chk("R9", "ready back", int'(ready), 1);
    chk("R7", "fwft marked word shown", int'(rd_data), 8'h91);
    rd();
    chk("R7", "fwft replay next", int'(rd_data), 8'h92);

    // fwft rewind without mark
    do_flush();
    wr(8'h40); wr(8'h41);
    rd();
    chk("R4", "second fwft word", int'(rd_data), 8'h41);
    do_rewind();
    chk("R8", "fwft zero rewind level", int'(level), 2);
    step(); step();
    chk("R8", "fwft replay from zero", int'(rd_data), 8'h40);

    summary();
    $finish;
  end

endmodule